// File: doc/BRIEF.md
# Viewport Scissor Rectangle Combiner

This block turns viewport-derived rectangles into the scissor register pairs that a rasterizer is programmed with. Each viewport rectangle arrives as signed fixed-point corners. Per axis the corners are put in order, the low corner is rounded down and the high corner rounded up, and both are clamped into the screen range 0 to 16384. The result can be replaced by the full screen range through a bypass control. An optional user scissor then narrows it. An optional legacy mode replaces any rectangle whose right or bottom edge is zero with a fixed 1,1 / 1,1 rectangle.

A start pulse begins a run. In single-viewport mode the run covers entry 0 only. In multi-viewport mode it covers all sixteen entries in index order, one per cycle. The block presents the entry index it wants on `ent_idx`, and the surrounding logic returns that entry's viewport and scissor corners in the same cycle. One cycle later the two packed words appear with `out_valid`. A `done` pulse follows the last pair.

Top module: `scis_combiner`

## Requirements
- R1: Viewport corners are signed fixed point with 4 fractional bits (17 integer bits). The low corner of each axis is rounded toward minus infinity and the high corner toward plus infinity.
- R2: If an axis's first corner is greater than its second, the two corners are exchanged before rounding.
- R3: Every rounded viewport coordinate is clamped to 0..16384 inclusive, so negative values become 0.
- R4: With bypass latched, the base rectangle is 0,0 to 16384,16384 whatever the viewport corners are.
- R5: With the scissor enable latched, each low bound becomes the larger of base and scissor, and each high bound the smaller. With it clear, the scissor corners have no effect.
- R6: With legacy mode latched, a final high X or high Y of 0 makes both words carry X=1, Y=1.
- R7: Word layout: X in bits 15:0, Y in bits 30:16. Bit 31 is 1 in the top-left word and 0 in the bottom-right word.
- R8: A single-viewport run emits exactly one pair, for entry 0, one cycle after the start is accepted.
- R9: A multi-viewport run emits 16 pairs on consecutive cycles, with `out_idx` counting 0 to 15.
- R10: `done` pulses for one cycle, the cycle after the last `out_valid`. `busy` is high from acceptance until the last entry is sampled.
- R11: Mode, bypass, legacy and scissor-enable are latched when a start is accepted. A start while busy is ignored and does not change the run.
- R12: After reset, `out_valid`, `done` and `busy` are 0 and `ent_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Run request, accepted when idle |
| multi_vp | input | 1 | 1: all 16 entries, 0: entry 0 only |
| full_range | input | 1 | Bypass: use the whole screen as base |
| legacy | input | 1 | Enable the degenerate-rectangle replacement |
| cut_en | input | 1 | Apply the user scissor |
| ent_idx | output | 4 | Entry whose corners are requested this cycle |
| vp_min_x | input | 21 | Viewport first X corner, signed fixed point |
| vp_min_y | input | 21 | Viewport first Y corner, signed fixed point |
| vp_max_x | input | 21 | Viewport second X corner, signed fixed point |
| vp_max_y | input | 21 | Viewport second Y corner, signed fixed point |
| cut_min_x | input | 15 | User scissor low X |
| cut_min_y | input | 15 | User scissor low Y |
| cut_max_x | input | 15 | User scissor high X |
| cut_max_y | input | 15 | User scissor high Y |
| busy | output | 1 | Run in progress |
| out_valid | output | 1 | Word pair valid |
| out_idx | output | 4 | Entry of the current word pair |
| tl_word | output | 32 | Packed top-left word |
| br_word | output | 32 | Packed bottom-right word |
| done | output | 1 | One-cycle pulse after the last pair |

## Verification
A wrong entry counter shows on the next `out_valid` cycle, as a repeated or skipped `out_idx` or a pair count other than 1 or 16. A wrong latched configuration corrupts the words of the first pair of the run. Rounding, swap and clamp faults show in the same word pair as the entry that triggers them, so each directed entry uses fractions, reversed corners, negatives and out-of-range values to make every path visible one cycle after it is requested.

// File: rtl/scis_pkg.sv
package scis_pkg;
  // word layout is fixed by the rasterizer that decodes it
  localparam int XW = 16;
  localparam int YW = 15;

  typedef struct packed {
    logic full_range;
    logic legacy;
    logic cut_en;
  } run_cfg_t;

  function automatic logic [31:0] pack_word(input logic flag,
                                            input logic [XW-1:0] x,
                                            input logic [YW-1:0] y);
    return {flag, y, x};
  endfunction
endpackage

// File: rtl/scis_axis.sv
module scis_axis #(
  parameter int INT_W = 17,
  parameter int FRAC_W = 4,
  parameter int LIMIT = 16384,
  localparam int CW = INT_W + FRAC_W,
  localparam int LW = $clog2(LIMIT + 1)
) (
  input  logic signed [CW-1:0] raw_a,
  input  logic signed [CW-1:0] raw_b,
  input  logic [LW-1:0]        cut_lo,
  input  logic [LW-1:0]        cut_hi,
  input  logic                 full_range,
  input  logic                 cut_en,
  output logic [LW-1:0]        lo,
  output logic [LW-1:0]        hi
);
  function automatic logic signed [INT_W:0] round_down(input logic signed [CW-1:0] v);
    logic signed [CW:0] w;
    w = {v[CW-1], v};
    return w[CW:FRAC_W];
  endfunction

  function automatic logic signed [INT_W:0] round_up(input logic signed [CW-1:0] v);
    logic signed [CW:0] w;
    w = {v[CW-1], v} + (CW+1)'((1 << FRAC_W) - 1);
    return w[CW:FRAC_W];
  endfunction

  function automatic logic [LW-1:0] squeeze(input logic signed [INT_W:0] v);
    if (v < 0) return '0;
    if (v > LIMIT) return LW'(LIMIT);
    return v[LW-1:0];
  endfunction

  logic                 swap_ab;
  logic signed [CW-1:0] small_c, large_c;
  logic [LW-1:0]        base_lo, base_hi;

  always_comb begin
    swap_ab = raw_a > raw_b;
    small_c = swap_ab ? raw_b : raw_a;
    large_c = swap_ab ? raw_a : raw_b;
    if (full_range) begin
      base_lo = '0;
      base_hi = LW'(LIMIT);
    end else begin
      base_lo = squeeze(round_down(small_c));
      base_hi = squeeze(round_up(large_c));
    end
    lo = base_lo;
    hi = base_hi;
    if (cut_en) begin
      lo = (cut_lo > base_lo) ? cut_lo : base_lo;
      hi = (cut_hi < base_hi) ? cut_hi : base_hi;
    end
  end
endmodule

// File: rtl/scis_seq.sv
module scis_seq #(
  parameter int N_VP = 16,
  localparam int IDX_W = (N_VP > 1) ? $clog2(N_VP) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             multi,
  output logic             busy,
  output logic [IDX_W-1:0] idx,
  output logic             accept,
  output logic             last,
  output logic             done
);
  logic multi_q, fin_q;

  assign accept = start && !busy;
  assign last   = busy && (multi_q ? (idx == IDX_W'(N_VP - 1)) : (idx == '0));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      idx     <= '0;
      multi_q <= 1'b0;
      fin_q   <= 1'b0;
      done    <= 1'b0;
    end else begin
      fin_q <= last;
      done  <= fin_q;
      if (accept) begin
        busy    <= 1'b1;
        idx     <= '0;
        multi_q <= multi;
      end else if (last) begin
        busy <= 1'b0;
      end else if (busy) begin
        idx <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/scis_combiner.sv
module scis_combiner
  import scis_pkg::*;
#(
  parameter int INT_W = 17,
  parameter int FRAC_W = 4,
  parameter int LIMIT = 16384,
  parameter int N_VP = 16,
  localparam int CW = INT_W + FRAC_W,
  localparam int LW = $clog2(LIMIT + 1),
  localparam int IDX_W = (N_VP > 1) ? $clog2(N_VP) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 multi_vp,
  input  logic                 full_range,
  input  logic                 legacy,
  input  logic                 cut_en,
  output logic [IDX_W-1:0]     ent_idx,
  input  logic signed [CW-1:0] vp_min_x,
  input  logic signed [CW-1:0] vp_min_y,
  input  logic signed [CW-1:0] vp_max_x,
  input  logic signed [CW-1:0] vp_max_y,
  input  logic [LW-1:0]        cut_min_x,
  input  logic [LW-1:0]        cut_min_y,
  input  logic [LW-1:0]        cut_max_x,
  input  logic [LW-1:0]        cut_max_y,
  output logic                 busy,
  output logic                 out_valid,
  output logic [IDX_W-1:0]     out_idx,
  output logic [31:0]          tl_word,
  output logic [31:0]          br_word,
  output logic                 done
);
  run_cfg_t cfg_q;
  logic     accept, last_ent;
  logic     leg_live;
  logic     degen;

  logic signed [CW-1:0] raw_a [2];
  logic signed [CW-1:0] raw_b [2];
  logic [LW-1:0] c_lo [2];
  logic [LW-1:0] c_hi [2];
  logic [LW-1:0] ax_lo [2];
  logic [LW-1:0] ax_hi [2];

  scis_seq #(.N_VP(N_VP)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .multi(multi_vp),
    .busy(busy), .idx(ent_idx), .accept(accept), .last(last_ent), .done(done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_q <= '0;
    else if (accept) cfg_q <= '{full_range: full_range, legacy: legacy, cut_en: cut_en};
  end

  assign raw_a[0] = vp_min_x;
  assign raw_b[0] = vp_max_x;
  assign raw_a[1] = vp_min_y;
  assign raw_b[1] = vp_max_y;
  assign c_lo[0]  = cut_min_x;
  assign c_hi[0]  = cut_max_x;
  assign c_lo[1]  = cut_min_y;
  assign c_hi[1]  = cut_max_y;

  for (genvar ax = 0; ax < 2; ax++) begin : g_ax
    scis_axis #(.INT_W(INT_W), .FRAC_W(FRAC_W), .LIMIT(LIMIT)) u_axis (
      .raw_a(raw_a[ax]), .raw_b(raw_b[ax]),
      .cut_lo(c_lo[ax]), .cut_hi(c_hi[ax]),
      .full_range(cfg_q.full_range), .cut_en(cfg_q.cut_en),
      .lo(ax_lo[ax]), .hi(ax_hi[ax])
    );
  end

  assign leg_live = cfg_q.legacy;
  assign degen    = leg_live && ((ax_hi[0] == '0) || (ax_hi[1] == '0));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_idx   <= '0;
      tl_word   <= '0;
      br_word   <= '0;
    end else begin
      out_valid <= busy;
      if (busy) begin
        out_idx <= ent_idx;
        if (degen) begin
          tl_word <= pack_word(1'b1, XW'(1), YW'(1));
          br_word <= pack_word(1'b0, XW'(1), YW'(1));
        end else begin
          tl_word <= pack_word(1'b1, XW'(ax_lo[0]), YW'(ax_lo[1]));
          br_word <= pack_word(1'b0, XW'(ax_hi[0]), YW'(ax_hi[1]));
        end
      end
    end
  end

  logic unused_last;
  assign unused_last = last_ent;
endmodule

// File: rtl/scis_combiner_chk.sv
module scis_combiner_chk #(
  parameter int LIMIT = 16384,
  parameter int N_VP = 16,
  localparam int IDX_W = (N_VP > 1) ? $clog2(N_VP) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic [IDX_W-1:0] ent_idx,
  input logic             out_valid,
  input logic [IDX_W-1:0] out_idx,
  input logic [31:0]      tl_word,
  input logic [31:0]      br_word,
  input logic             done,
  input logic             leg_live
);
  // R7
  corner_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (tl_word[31] && !br_word[31]));

  // R3
  coord_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (tl_word[15:0] <= 16'(LIMIT) && br_word[15:0] <= 16'(LIMIT) &&
                   tl_word[30:16] <= 15'(LIMIT) && br_word[30:16] <= 15'(LIMIT)));

  // R9
  entry_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid)) |-> (out_idx == IDX_W'($past(out_idx) + 1'b1)));

  // R10
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!out_valid && $past(out_valid)));

  // R6
  legacy_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && leg_live) |-> (br_word[15:0] != 16'd0 && br_word[30:16] != 15'd0));

  // R11
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (ent_idx == IDX_W'($past(ent_idx) + 1'b1)));
endmodule

bind scis_combiner scis_combiner_chk #(.LIMIT(LIMIT), .N_VP(N_VP)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .ent_idx(ent_idx),
  .out_valid(out_valid), .out_idx(out_idx), .tl_word(tl_word),
  .br_word(br_word), .done(done), .leg_live(leg_live)
);

// File: tb/scis_combiner_test.sv
module scis_combiner_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, multi_vp = 1'b0, full_range = 1'b0, legacy = 1'b0, cut_en = 1'b0;
  logic [3:0] ent_idx, out_idx;
  logic signed [20:0] vp_min_x, vp_min_y, vp_max_x, vp_max_y;
  logic [14:0] cut_min_x, cut_min_y, cut_max_x, cut_max_y;
  logic busy, out_valid, done;
  logic [31:0] tl_word, br_word;

  int vt [16][4];
  int st [16][4];
  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  assign vp_min_x  = 21'(vt[ent_idx][0]);
  assign vp_min_y  = 21'(vt[ent_idx][1]);
  assign vp_max_x  = 21'(vt[ent_idx][2]);
  assign vp_max_y  = 21'(vt[ent_idx][3]);
  assign cut_min_x = 15'(st[ent_idx][0]);
  assign cut_min_y = 15'(st[ent_idx][1]);
  assign cut_max_x = 15'(st[ent_idx][2]);
  assign cut_max_y = 15'(st[ent_idx][3]);

  scis_combiner uut (.*);

  function automatic int dn(int v); return int'($floor(real'(v) / 16.0)); endfunction
  function automatic int up(int v); return int'($ceil(real'(v) / 16.0)); endfunction
  function automatic int lim(int v); return (v < 0) ? 0 : ((v > 16384) ? 16384 : v); endfunction

  task automatic model(input int i, input bit byp, input bit leg, input bit sce,
                       output logic [31:0] etl, output logic [31:0] ebr);
    int lo[2], hi[2];
    for (int ax = 0; ax < 2; ax++) begin
      int a = vt[i][ax];
      int b = vt[i][ax+2];
      int s = (a < b) ? a : b;
      int g = (a < b) ? b : a;
      lo[ax] = byp ? 0 : lim(dn(s));
      hi[ax] = byp ? 16384 : lim(up(g));
      if (sce) begin
        if (st[i][ax] > lo[ax]) lo[ax] = st[i][ax];
        if (st[i][ax+2] < hi[ax]) hi[ax] = st[i][ax+2];
      end
    end
    if (leg && (hi[0] == 0 || hi[1] == 0)) begin
      lo[0] = 1; lo[1] = 1; hi[0] = 1; hi[1] = 1;
    end
    etl = 32'h8000_0000 | (32'(lo[1]) << 16) | 32'(lo[0]);
    ebr = (32'(hi[1]) << 16) | 32'(hi[0]);
  endtask

  task automatic chk(input string req, input bit ok, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // starts a run, checks every pair, the count and the done pulse
  task automatic run_seq(input string req, input bit mul, input bit byp, input bit leg,
                         input bit sce, input bit poke);
    int n = 0;
    bit seen_done = 0;
    logic [31:0] etl, ebr;
    @(negedge clk);
    multi_vp = mul; full_range = byp; legacy = leg; cut_en = sce; start = 1'b1;
    for (int i = 0; i < 40 && !seen_done; i++) begin
      @(negedge clk);
      if (i == 0) start = 1'b0;
      if (poke && i == 5) begin start = 1'b1; full_range = !byp; legacy = !leg; multi_vp = 1'b0; end
      if (poke && i == 6) begin start = 1'b0; full_range = byp; legacy = leg; end
      if (out_valid) begin
        model(int'(out_idx), byp, leg, sce, etl, ebr);
        chk(req, out_idx == 4'(n), "entry index", 64'(out_idx), 64'(n));
        chk(req, tl_word == etl && br_word == ebr, $sformatf("words idx %0d", n),
            {tl_word, br_word}, {etl, ebr});
        n++;
      end
      if (done) seen_done = 1;
    end
    chk(mul ? "R9" : "R8", n == (mul ? 16 : 1), "pair count", 64'(n), mul ? 64'd16 : 64'd1);
    chk("R10", seen_done, "done seen", 64'(seen_done), 64'd1);
    @(negedge clk);
    chk("R10", !done && !out_valid && !busy, "idle after done",
        {61'd0, done, out_valid, busy}, 64'd0);
  endtask

  task automatic set0(input int a, input int b, input int c, input int d);
    vt[0][0] = a; vt[0][1] = b; vt[0][2] = c; vt[0][3] = d;
  endtask

  task automatic t_reset;
    chk("R12", !out_valid && !done && !busy && ent_idx == 4'd0, "reset state",
        {58'd0, out_valid, done, busy, ent_idx == 4'd0}, 64'd1);
  endtask

  task automatic t_round;   // R1
    set0(10*16+8, 20*16+4, 100*16+1, 200*16);
    run_seq("R1", 0, 0, 0, 0, 0);
    set0(-3*16-5, 7*16+15, 4*16+15, 9*16+1);
    run_seq("R1", 0, 0, 0, 0, 0);
  endtask

  task automatic t_swap;    // R2 and R3
    set0(3000*16+3, 500*16, 12*16+9, 40*16+2);
    run_seq("R2", 0, 0, 0, 0, 0);
    set0(-900*16, 30000*16, 20000*16, -7*16);
    run_seq("R3", 0, 0, 0, 0, 0);
  endtask

  task automatic t_bypass;  // R4
    set0(5*16, 6*16, 7*16, 8*16);
    run_seq("R4", 0, 1, 0, 0, 0);
  endtask

  task automatic t_cut;     // R5
    set0(10*16, 10*16, 900*16, 700*16);
    st[0][0] = 50; st[0][1] = 5; st[0][2] = 400; st[0][3] = 800;
    run_seq("R5", 0, 0, 0, 1, 0);
    run_seq("R5", 0, 0, 0, 0, 0);
    run_seq("R5", 0, 1, 0, 1, 0);
  endtask

  task automatic t_legacy;  // R6 and R7
    set0(-50*16, 10*16, -2*16, 60*16);
    run_seq("R6", 0, 0, 1, 0, 0);
    run_seq("R7", 0, 0, 0, 0, 0);
    set0(4*16, -30*16, 90*16, -1);
    run_seq("R6", 0, 0, 1, 0, 0);
  endtask

  task automatic t_multi;   // R9 and R11
    for (int k = 0; k < 16; k++) begin
      vt[k][0] = k*1000*16 - 20000 + k;
      vt[k][2] = vt[k][0] + ((k % 3 == 0) ? -3000*16 : 7000*16 + 5);
      vt[k][1] = (k*2100 - 5000)*16 + 8;
      vt[k][3] = vt[k][1] + 900*16 + (k % 4)*3;
      st[k][0] = k*300; st[k][1] = k*150;
      st[k][2] = 16384 - k*500; st[k][3] = 9000 + k*100;
    end
    run_seq("R9", 1, 0, 0, 1, 0);
    run_seq("R11", 1, 0, 1, 0, 1);
    run_seq("R9", 1, 1, 0, 1, 0);
  endtask

  initial begin
    for (int k = 0; k < 16; k++)
      for (int j = 0; j < 4; j++) begin vt[k][j] = 0; st[k][j] = 0; end
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_round();
    t_swap();
    t_bypass();
    t_cut();
    t_legacy();
    t_multi();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule